// File: doc/BRIEF.md
# MSI Snooping Cache Coherence Controller

This block keeps one core's small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Every line holds one word, an address tag and one of three states: Modified (dirty and exclusive), Shared (clean, possibly held elsewhere) or Invalid. The core presents load, store and write-back requests. The controller completes a request at once when the line's state allows it. Otherwise it requests the bus and holds the request until an arbiter grants the bus, then completes it during the granted cycle.

Whenever another controller owns the bus, this block watches the broadcast command and address. It hands over its dirty word when a peer misses on a line it holds Modified, and it downgrades or invalidates its own copy. A bus transaction lasts one cycle. The requester receives read data in that same cycle, either from the peer that supplied it or from memory. The arbiter, the memory and the bus multiplexing sit outside the block.

Bus command encoding: 0 idle, 1 read miss, 2 write miss (also used for upgrades), 3 write-back. Core operation encoding: 0 load, 1 store, 2 write-back. The address splits into line index (low bits) and tag (high bits).

Top module: `msi_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus request is raised, and the first load of any address issues a read miss (command 1).
- R2: A load that misses completes in its granted read-miss cycle, returns bus_rdata and leaves the line Shared. A later load of the same address hits with no bus request and returns the same word.
- R3: A store to a line that is absent or Invalid issues a write miss (command 2) and leaves the line Modified. A store to a Modified line completes with no bus request.
- R4: A store to a Shared line is an upgrade: it issues command 2 and completes only in the granted cycle.
- R5: A snooped read miss that hits a Modified line raises snp_flush with the dirty word and moves the line to Shared, so a later local load hits and a later local store needs an upgrade.
- R6: A snooped write miss invalidates a Shared or Modified line. A Modified line supplies its dirty word first through snp_flush.
- R7: A snooped read miss that hits a Shared line, or that misses, raises no snp_flush and leaves the state unchanged.
- R8: A local write-back of a Modified line issues command 3 with its data and leaves the line Invalid. A write-back of a Shared line completes with no bus traffic and also leaves the line Invalid.
- R9: A load or store that conflicts with a different Modified tag in its line first writes the victim back with command 3, then issues its own miss.
- R10: A request that needs the bus keeps bus_req high and does not complete until bus_gnt is given. A snoop aimed at the same line index holds back a local hit for that cycle.
- R11: No two controllers supply dirty data at once, and two cores that increment a shared word through the caches see a single, consistent value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| core_valid | input | 1 | Core request present, held until core_done |
| core_op | input | 2 | 0 load, 1 store, 2 write-back |
| core_addr | input | AW | Word address of the request |
| core_wdata | input | DW | Store data |
| core_done | output | 1 | Request completes this cycle |
| core_rdata | output | DW | Load result, valid with core_done |
| bus_req | output | 1 | Needs a bus transaction |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd | output | 2 | Command driven while granted |
| bus_addr | output | AW | Address of the transaction |
| bus_wdata | output | DW | Write-back data |
| bus_rdata | input | DW | Data returned to the requester |
| snp_valid | input | 1 | A transaction is on the bus |
| snp_cmd | input | 2 | Command being snooped |
| snp_addr | input | AW | Address being snooped |
| snp_flush | output | 1 | This cache supplies dirty data |
| snp_data | output | DW | Supplied dirty word |

## Verification
A line left in the wrong state shows up on the ports at the next access to that address. A stale Modified copy raises snp_flush or skips an upgrade. A stale Shared copy returns an old word with no bus request, and a stale Invalid copy issues a read miss that should not happen. The reference model runs alongside both controllers and compares bus_req, bus_cmd, core_done, core_rdata and snp_flush on every cycle. A state error is therefore reported in the first cycle in which any core or peer touches the affected line.

// File: rtl/msi_ctrl.sv
module msi_ctrl #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int LINES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_valid,
  input  logic [1:0]    core_op,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          core_done,
  output logic [DW-1:0] core_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_flush,
  output logic [DW-1:0] snp_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_WB = 2'd2;
  localparam logic [1:0] CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_WB = 2'd3;

  logic [1:0]    st_q  [LINES];
  logic [TW-1:0] tag_q [LINES];
  logic [DW-1:0] dat_q [LINES];

  wire [IW-1:0] c_idx = core_addr[IW-1:0];
  wire [TW-1:0] c_tag = core_addr[AW-1:IW];
  wire [IW-1:0] s_idx = snp_addr[IW-1:0];
  wire [TW-1:0] s_tag = snp_addr[AW-1:IW];

  wire [1:0] c_st     = st_q[c_idx];
  wire       c_hit    = (c_st != ST_I) && (tag_q[c_idx] == c_tag);
  wire       c_victim = (c_st == ST_M) && !c_hit;

  wire s_act  = snp_valid && !bus_gnt;
  wire s_hit  = s_act && (st_q[s_idx] != ST_I) && (tag_q[s_idx] == s_tag);
  wire blocked = s_act && (s_idx == c_idx);

  logic [1:0] need;
  always_comb begin
    need = CMD_NONE;
    if (core_valid) begin
      case (core_op)
        OP_LD: if (!c_hit) need = c_victim ? CMD_WB : CMD_RD;
        OP_ST: if (!c_hit) need = c_victim ? CMD_WB : CMD_RDX;
               else if (c_st == ST_S) need = CMD_RDX;
        OP_WB: if (c_hit && c_st == ST_M) need = CMD_WB;
        default: ;
      endcase
    end
  end

  wire evict_only = (need == CMD_WB) && (core_op != OP_WB);

  assign bus_req    = (need != CMD_NONE);
  assign bus_cmd    = bus_gnt ? need : CMD_NONE;
  assign bus_addr   = (need == CMD_WB) ? {tag_q[c_idx], c_idx} : core_addr;
  assign bus_wdata  = dat_q[c_idx];
  assign core_done  = core_valid &&
                      ((need == CMD_NONE && !blocked) ||
                       (bus_gnt && need != CMD_NONE && !evict_only));
  assign core_rdata = (bus_gnt && need == CMD_RD) ? bus_rdata : dat_q[c_idx];
  assign snp_flush  = s_hit && (st_q[s_idx] == ST_M) &&
                      (snp_cmd == CMD_RD || snp_cmd == CMD_RDX);
  assign snp_data   = dat_q[s_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      if (s_hit) begin
        if (snp_cmd == CMD_RDX) st_q[s_idx] <= ST_I;
        else if (snp_cmd == CMD_RD && st_q[s_idx] == ST_M) st_q[s_idx] <= ST_S;
      end
      if (bus_gnt && need == CMD_WB) begin
        st_q[c_idx] <= ST_I;
      end else if (core_done) begin
        case (core_op)
          OP_LD: if (need == CMD_RD) begin
            st_q[c_idx]  <= ST_S;
            tag_q[c_idx] <= c_tag;
            dat_q[c_idx] <= bus_rdata;
          end
          OP_ST: begin
            st_q[c_idx]  <= ST_M;
            tag_q[c_idx] <= c_tag;
            dat_q[c_idx] <= core_wdata;
          end
          OP_WB: if (c_hit) st_q[c_idx] <= ST_I;
          default: ;
        endcase
      end
    end
  end
endmodule

module msi_ctrl_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_valid,
  input logic [1:0]    core_op,
  input logic          core_done,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [1:0]    bus_cmd,
  input logic          snp_valid,
  input logic [AW-1:0] snp_addr,
  input logic          snp_flush
);
  a_r10_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> bus_req);
  a_r10_stall_until_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |-> !core_done);
  a_r2_load_miss_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && core_valid && core_op == 2'd0 && bus_cmd != 2'd3) |-> bus_cmd == 2'd1);
  a_r4_store_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && core_valid && core_op == 2'd1 && bus_cmd != 2'd3) |-> bus_cmd == 2'd2);
  a_r8_wb_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && core_valid && core_op == 2'd2) |-> bus_cmd == 2'd3);
  a_r6_flush_on_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_valid && !bus_gnt));
  a_r5_flush_once: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |=> !(snp_flush && snp_addr == $past(snp_addr)));
endmodule

bind msi_ctrl msi_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_op(core_op),
  .core_done(core_done), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
  .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_flush(snp_flush)
);

// File: tb/tb_msi_ctrl.sv
module tb_msi_ctrl;
  localparam int AW = 8, DW = 32, LINES = 4, NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cv   [NC];
  logic [1:0]    cop  [NC];
  logic [AW-1:0] ca   [NC];
  logic [DW-1:0] cw   [NC];
  logic          done [NC];
  logic [DW-1:0] crd  [NC];
  logic          breq [NC];
  logic [1:0]    bcmd [NC];
  logic [AW-1:0] baddr[NC];
  logic [DW-1:0] bwd  [NC];
  logic          fl   [NC];
  logic [DW-1:0] fdat [NC];
  logic [NC-1:0] gnt;
  logic          rr;

  logic [DW-1:0] mem [256];
  wire           any_g = |gnt;
  wire [1:0]     s_cmd = gnt[1] ? bcmd[1] : bcmd[0];
  wire [AW-1:0]  s_addr = gnt[1] ? baddr[1] : baddr[0];
  wire [DW-1:0]  brd = fl[0] ? fdat[0] : (fl[1] ? fdat[1] : mem[s_addr]);

  always_comb begin
    gnt = '0;
    if (breq[rr]) gnt[rr] = 1'b1;
    else if (breq[!rr]) gnt[!rr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr <= 1'b0;
    else if (any_g) rr <= !gnt[1] ? 1'b1 : 1'b0;
    if (rst_n && any_g) begin
      if (fl[0] || fl[1]) mem[s_addr] <= brd;
      if (s_cmd == 2'd3) mem[s_addr] <= gnt[1] ? bwd[1] : bwd[0];
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_cpu
    msi_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) dut (
      .clk(clk), .rst_n(rst_n),
      .core_valid(cv[i]), .core_op(cop[i]), .core_addr(ca[i]), .core_wdata(cw[i]),
      .core_done(done[i]), .core_rdata(crd[i]),
      .bus_req(breq[i]), .bus_gnt(gnt[i]), .bus_cmd(bcmd[i]), .bus_addr(baddr[i]),
      .bus_wdata(bwd[i]), .bus_rdata(brd),
      .snp_valid(any_g), .snp_cmd(s_cmd), .snp_addr(s_addr),
      .snp_flush(fl[i]), .snp_data(fdat[i])
    );
  end

  int nchk = 0, nfail = 0, cyc = 0;
  int flushes [NC];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model: per-core line state (0 I, 1 S, 2 M), tag, data; memory image
  int rs [NC][LINES];
  int rt [NC][LINES];
  int rdt[NC][LINES];
  int rmem[256];

  always @(negedge clk) begin
    int ecmd[NC];
    int idx[NC];
    bit hit[NC];
    bit eflush[NC];
    bit sact[NC];
    bit edone;
    int g, sidx, stg, busd;
    cyc++;
    if (rst_n) begin
      g = gnt[0] ? 0 : (gnt[1] ? 1 : -1);
      sidx = (g >= 0) ? int'(baddr[g]) % LINES : 0;
      stg  = (g >= 0) ? int'(baddr[g]) / LINES : 0;
      for (int i = 0; i < NC; i++) begin
        idx[i] = int'(ca[i]) % LINES;
        hit[i] = rs[i][idx[i]] != 0 && rt[i][idx[i]] == int'(ca[i]) / LINES;
        ecmd[i] = 0;
        if (cv[i]) begin
          if (cop[i] == 2'd0 && !hit[i]) ecmd[i] = (rs[i][idx[i]] == 2) ? 3 : 1;
          if (cop[i] == 2'd1 && !hit[i]) ecmd[i] = (rs[i][idx[i]] == 2) ? 3 : 2;
          if (cop[i] == 2'd1 && hit[i] && rs[i][idx[i]] == 1) ecmd[i] = 2;
          if (cop[i] == 2'd2 && hit[i] && rs[i][idx[i]] == 2) ecmd[i] = 3;
        end
        sact[i] = g >= 0 && g != i;
        eflush[i] = sact[i] && rs[i][sidx] == 2 && rt[i][sidx] == stg &&
                    (bcmd[g] == 2'd1 || bcmd[g] == 2'd2);
      end
      busd = (g >= 0) ? rmem[baddr[g]] : 0;
      for (int i = 0; i < NC; i++) if (eflush[i]) busd = rdt[i][sidx];
      chk(!(fl[0] && fl[1]), "R11", "two suppliers at once", 1, 0);
      for (int i = 0; i < NC; i++) begin
        edone = cv[i] && ((ecmd[i] == 0 && !(sact[i] && sidx == idx[i])) ||
                          (gnt[i] && ecmd[i] != 0 && !(ecmd[i] == 3 && cop[i] != 2'd2)));
        chk(breq[i] == (ecmd[i] != 0), "R10", "bus_req", breq[i], ecmd[i] != 0);
        chk(int'(bcmd[i]) == (gnt[i] ? ecmd[i] : 0), "R3", "bus_cmd", bcmd[i], gnt[i] ? ecmd[i] : 0);
        chk(done[i] == edone, "R10", "core_done", done[i], edone);
        chk(fl[i] == eflush[i], "R5", "snp_flush", fl[i], eflush[i]);
        if (edone && cop[i] == 2'd0)
          chk(int'(crd[i]) == (ecmd[i] == 1 ? busd : rdt[i][idx[i]]), "R2", "core_rdata",
              crd[i], ecmd[i] == 1 ? busd : rdt[i][idx[i]]);
        hit[i] = edone;
      end
      // state update as of the coming edge
      if (g >= 0) begin
        for (int i = 0; i < NC; i++) if (sact[i] && rs[i][sidx] != 0 && rt[i][sidx] == stg) begin
          if (bcmd[g] == 2'd2) rs[i][sidx] = 0;
          else if (bcmd[g] == 2'd1 && rs[i][sidx] == 2) rs[i][sidx] = 1;
        end
        if (eflush[0] || eflush[1]) rmem[baddr[g]] = busd;
        if (bcmd[g] == 2'd3) rmem[baddr[g]] = int'(bwd[g]);
      end
      for (int i = 0; i < NC; i++) begin
        if (gnt[i] && ecmd[i] == 3) rs[i][idx[i]] = 0;
        else if (hit[i]) begin
          if (cop[i] == 2'd0 && ecmd[i] == 1) begin
            rs[i][idx[i]] = 1; rt[i][idx[i]] = int'(ca[i]) / LINES; rdt[i][idx[i]] = busd;
          end else if (cop[i] == 2'd1) begin
            rs[i][idx[i]] = 2; rt[i][idx[i]] = int'(ca[i]) / LINES; rdt[i][idx[i]] = int'(cw[i]);
          end else if (cop[i] == 2'd2 && rs[i][idx[i]] == 1 && rt[i][idx[i]] == int'(ca[i]) / LINES)
            rs[i][idx[i]] = 0;
        end
      end
      for (int i = 0; i < NC; i++) if (fl[i]) flushes[i]++;
    end
  end

  task automatic do_op(int i, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] w,
                       output logic [DW-1:0] rd, output logic [3:0] mask, output int t);
    mask = '0;
    rd = '0;
    t = 0;
    cv[i] = 1'b1; cop[i] = op; ca[i] = a; cw[i] = w;
    forever begin
      @(negedge clk);
      if (gnt[i]) mask |= 4'(1 << bcmd[i]);
      if (done[i]) begin rd = crd[i]; t = cyc; break; end
    end
    @(posedge clk); #1;
    cv[i] = 1'b0;
  endtask

  task automatic inc(int i, logic [AW-1:0] a);
    logic [DW-1:0] v;
    logic [3:0] m;
    int t;
    do_op(i, 2'd0, a, '0, v, m, t);
    do_op(i, 2'd1, a, v + 1, v, m, t);
  endtask

  localparam logic [AW-1:0] A = 8'h10, B = 8'h14, C = 8'h21, W = 8'h30;

  initial begin
    logic [DW-1:0] rd, rd1;
    logic [3:0] m, m1;
    int t, t1, f0, f1;
    for (int i = 0; i < NC; i++) begin
      cv[i] = 1'b0; cop[i] = '0; ca[i] = '0; cw[i] = '0; flushes[i] = 0;
      for (int k = 0; k < LINES; k++) begin rs[i][k] = 0; rt[i][k] = 0; rdt[i][k] = 0; end
    end
    for (int k = 0; k < 256; k++) begin mem[k] = 32'h100 + k; rmem[k] = 32'h100 + k; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!breq[0] && !breq[1] && !done[0] && !done[1], "R1", "idle after reset", 1, 0);
    @(posedge clk); #1;

    do_op(0, 2'd0, A, '0, rd, m, t);
    chk(m == 4'b0010, "R1", "first load issues read miss", m, 4'b0010);
    chk(rd == 32'h110, "R2", "load miss data", rd, 32'h110);
    do_op(0, 2'd0, A, '0, rd, m, t);
    chk(m == 4'b0000 && rd == 32'h110, "R2", "load hit no bus", m, 0);

    f0 = flushes[0];
    do_op(1, 2'd0, A, '0, rd, m, t);
    chk(flushes[0] == f0 && rd == 32'h110, "R7", "shared peer no flush", flushes[0] - f0, 0);

    do_op(0, 2'd1, A, 32'h55, rd, m, t);
    chk(m == 4'b0100, "R4", "upgrade on shared store", m, 4'b0100);
    f0 = flushes[0];
    do_op(1, 2'd0, A, '0, rd, m, t);
    chk(flushes[0] == f0 + 1, "R5", "modified owner flushes", flushes[0] - f0, 1);
    chk(rd == 32'h55, "R5", "flushed data to reader", rd, 32'h55);
    do_op(0, 2'd0, A, '0, rd, m, t);
    chk(m == 4'b0000 && rd == 32'h55, "R5", "owner kept shared copy", m, 0);
    do_op(0, 2'd1, A, 32'h66, rd, m, t);
    chk(m == 4'b0100, "R5", "store after downgrade upgrades", m, 4'b0100);

    f0 = flushes[0];
    do_op(1, 2'd1, A, 32'h77, rd, m, t);
    chk(m == 4'b0100 && flushes[0] == f0 + 1, "R6", "write miss flushes owner", flushes[0] - f0, 1);
    f1 = flushes[1];
    do_op(0, 2'd0, A, '0, rd, m, t);
    chk(m == 4'b0010 && rd == 32'h77, "R6", "invalidated owner misses", rd, 32'h77);
    chk(flushes[1] == f1 + 1, "R5", "new owner flushes", flushes[1] - f1, 1);

    do_op(1, 2'd1, C, 32'h12, rd, m, t);
    chk(m == 4'b0100, "R3", "store miss write miss", m, 4'b0100);
    do_op(1, 2'd1, C, 32'h13, rd, m, t);
    chk(m == 4'b0000, "R3", "store hit modified", m, 0);

    do_op(1, 2'd2, C, '0, rd, m, t);
    chk(m == 4'b1000 && mem[C] == 32'h13, "R8", "dirty write-back", mem[C], 32'h13);
    do_op(1, 2'd0, C, '0, rd, m, t);
    chk(m == 4'b0010 && rd == 32'h13, "R8", "line invalid after write-back", m, 4'b0010);
    do_op(1, 2'd2, C, '0, rd, m, t);
    chk(m == 4'b0000, "R8", "clean write-back silent", m, 0);
    do_op(1, 2'd0, C, '0, rd, m, t);
    chk(m == 4'b0010, "R8", "clean line dropped", m, 4'b0010);

    do_op(0, 2'd1, A, 32'h88, rd, m, t);
    do_op(0, 2'd0, B, '0, rd, m, t);
    chk(m == 4'b1010 && rd == 32'h114, "R9", "victim write-back then miss", m, 4'b1010);
    chk(mem[A] == 32'h88, "R9", "victim data in memory", mem[A], 32'h88);
    do_op(0, 2'd0, A, '0, rd, m, t);
    chk(m == 4'b0010 && rd == 32'h88, "R9", "reload after eviction", rd, 32'h88);

    fork
      do_op(0, 2'd0, 8'h40, '0, rd, m, t);
      do_op(1, 2'd0, 8'h41, '0, rd1, m1, t1);
    join
    chk(t != t1 && m == 4'b0010 && m1 == 4'b0010, "R10", "grants serialized", t - t1, 1);

    for (int k = 0; k < 16; k++) inc(k % 2, W);
    do_op(0, 2'd0, W, '0, rd, m, t);
    chk(rd == 32'h140, "R11", "alternating increments", rd, 32'h140);
    fork
      for (int k = 0; k < 4; k++) inc(0, W);
      for (int k = 0; k < 4; k++) inc(1, W);
    join
    do_op(0, 2'd0, W, '0, rd, m, t);
    do_op(1, 2'd0, W, '0, rd1, m1, t1);
    chk(rd == rd1 && rd > 32'h140, "R11", "single consistent value", rd1, rd);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R10 watchdog expired: got %0d expected %0d", 100000, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule